// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer with Dual Alarms

This block paces the once-per-second update of a real-time clock. It counts ticks of a 32.768 kHz enable. A fixed number of ticks before each second boundary it raises an update-in-progress status bit, so that software stops reading the time bytes while they are about to change. At the boundary it issues a one-cycle advance strobe. An external calendar block acts on that strobe by moving the time and date bytes forward.

Two clock cycles after the strobe, the advanced time is stable at the inputs. In that cycle the sequencer drops update-in-progress and sets a sticky update-ended flag. In the same cycle it compares two alarm sets against the new time and sets their sticky flags. The short alarm set covers seconds, minutes and hours. The long alarm set covers all eight time and date bytes. Any alarm byte whose two top bits are both 1 matches every value.

The time bytes are packed into one 64-bit bus with seconds in the lowest byte. Each flag is cleared by its own one-cycle strobe.

Top module: `rtc_upd_seq`

## Requirements
- R1: After reset releases, `uip_o` rises in the clock cycle that follows the (TICKS_PER_SEC − LEAD_TICKS)-th tick (a cycle with `tick_en_i` high). It then rises again once every TICKS_PER_SEC ticks.
- R2: `adv_o` is high for exactly one cycle. That cycle follows the tick that comes LEAD_TICKS ticks after the tick that raised `uip_o`. While `adv_o` is high, `uip_o` is high.
- R3: In the second cycle after `adv_o` was high, `uip_o` is low and `uf_o` is high.
- R4: Exactly one advance strobe and one update-in-progress interval occur every TICKS_PER_SEC ticks. Each later strobe comes TICKS_PER_SEC ticks after the previous one.
- R5: `afa_o` is set when `cur_time_i[23:0]` (hours in [23:16], minutes in [15:8], seconds in [7:0]) matches `alarm_a_i` byte by byte. The time used is the value present in the cycle in which `uip_o` falls, which is the advanced time, and not the time before the advance.
- R6: `afb_o` is set when all eight bytes of `cur_time_i` match `alarm_b_i`. The byte order is seconds [7:0], minutes [15:8], hours [23:16], day of week [31:24], date [39:32], month [47:40], year [55:48], century [63:56]. A single differing byte prevents the flag from being set.
- R7: An alarm byte with bits [7:6] equal to 2'b11 (for example C0h or FFh) matches any time byte. A byte with only bit 7 set (80h) or only bit 6 set (40h) is compared as an ordinary value.
- R8: `uf_o`, `afa_o` and `afb_o` keep their value until their own clear strobe (`clr_uf_i`, `clr_afa_i`, `clr_afb_i`). A clear strobe without a set clears only its own flag, and the flag reads low in the following cycle.
- R9: When a clear strobe and a set of the same flag occur in the same cycle, the flag is set.
- R10: Alarm flags are set only in the cycle in which `uip_o` falls. A time that matches an alarm during the rest of the second does not set the flag.
- R11: While `rst_n` is low, and after its release until the first tick, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| cur_time_i | input | 64 | Current time and calendar bytes, seconds in the low byte |
| alarm_a_i | input | 24 | Alarm A hours, minutes and seconds |
| alarm_b_i | input | 64 | Alarm B bytes, same layout as the time bus |
| clr_uf_i | input | 1 | Clear strobe for the update-ended flag |
| clr_afa_i | input | 1 | Clear strobe for alarm flag A |
| clr_afb_i | input | 1 | Clear strobe for alarm flag B |
| uip_o | output | 1 | Update in progress |
| adv_o | output | 1 | One-cycle strobe that advances the calendar |
| uf_o | output | 1 | Sticky update-ended flag |
| afa_o | output | 1 | Sticky alarm A flag |
| afb_o | output | 1 | Sticky alarm B flag |

## Verification
The in-line assertions check, on every cycle, the shape of the sequence:
- the advance strobe lasts one cycle and falls inside update-in-progress;
- update-in-progress clears exactly two cycles after the strobe, together with the update-ended flag;
- alarm flags rise only at that clear;
- the flags hold, clear and give priority to a set.

Only the bench scenarios can show the things that depend on counting ticks and on byte values:
- the absolute tick positions of the rise and the strobe;
- that the comparison uses the advanced time;
- per-byte matching and mismatching for each alarm set;
- wildcard handling of C0h, FFh, 80h and 40h.

// File: rtl/rtc_upd_pkg.sv
// Package: shared widths and the alarm wildcard rule for the update sequencer.
// Assumes 8-bit time bytes packed with seconds in the lowest byte.
package rtc_upd_pkg;

    localparam int BYTE_W        = 8;
    localparam int TIME_BYTES    = 8;
    localparam int ALM_A_BYTES   = 3;
    localparam int TIME_W        = BYTE_W * TIME_BYTES;
    localparam int ALM_A_W       = BYTE_W * ALM_A_BYTES;
    localparam int NUM_FLAGS     = 3;

    // Flag slots in the sticky flag vector
    localparam int FLAG_UF  = 0;
    localparam int FLAG_AFA = 1;
    localparam int FLAG_AFB = 2;

    // An alarm byte with both top bits set matches any value
    function automatic logic is_wildcard(input logic [BYTE_W-1:0] b);
        return (b[BYTE_W-1] && b[BYTE_W-2]);
    endfunction

endpackage

// File: rtl/rtc_tick_timer.sv
// Module: rtc_tick_timer
// Counts enable ticks inside one second and produces the update sequence.
// The sequence is: raise update-in-progress, issue the advance strobe LEAD
// ticks later, then finish two cycles after the strobe.
// Assumes LEAD >= 1, LEAD < TICKS - 1, and at least two clocks between ticks.
module rtc_tick_timer #(
    parameter int TICKS = 32768,
    parameter int LEAD  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic uip_o,
    output logic adv_o,
    output logic fin_o
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(TICKS - 1);
    localparam logic [CW-1:0] RISE_CNT = CW'(TICKS - 1 - LEAD);

    logic [CW-1:0] sub_cnt;
    logic          uip_q;
    logic          adv_q;
    logic          fin_q;

    // Sub-second tick counter, wraps once per second
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_cnt <= '0;
        else if (tick_i)
            sub_cnt <= (sub_cnt == LAST_CNT) ? '0 : sub_cnt + 1'b1;
    end

    // Advance strobe on the last tick of the second; finish one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            adv_q <= tick_i && (sub_cnt == LAST_CNT);
            fin_q <= adv_q;
        end
    end

    // Update-in-progress: set LEAD ticks ahead of the strobe, cleared at finish
    always_ff @(posedge clk) begin
        if (!rst_n)
            uip_q <= 1'b0;
        else if (fin_q)
            uip_q <= 1'b0;
        else if (tick_i && (sub_cnt == RISE_CNT))
            uip_q <= 1'b1;
    end

    assign uip_o = uip_q;
    assign adv_o = adv_q;
    assign fin_o = fin_q;

    AST_UIP_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_q) |-> $past(tick_i)); // R1
    AST_ADV_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q |=> !adv_q); // R2
    AST_ADV_INSIDE_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q |-> uip_q); // R2
    AST_UIP_CLEARS_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip_q) |-> $past(adv_q, 2)); // R3

endmodule

// File: rtl/rtc_alarm_match.sv
// Module: rtc_alarm_match
// Byte-wise comparison of an alarm set against the matching time bytes.
// A byte matches when it is equal or when the alarm byte is a wildcard.
// Purely combinational; the caller decides when the result is used.
module rtc_alarm_match
    import rtc_upd_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic [NBYTES*BYTE_W-1:0] time_i,
    input  logic [NBYTES*BYTE_W-1:0] alarm_i,
    output logic                     hit_o
);

    logic [NBYTES-1:0] byte_ok;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] t_b;
        logic [BYTE_W-1:0] a_b;
        assign t_b = time_i [g*BYTE_W +: BYTE_W];
        assign a_b = alarm_i[g*BYTE_W +: BYTE_W];
        // One byte: exact value or wildcard
        always_comb byte_ok[g] = is_wildcard(a_b) || (a_b == t_b);
    end

    assign hit_o = &byte_ok;

endmodule

// File: rtl/rtc_sticky_flag.sv
// Module: rtc_sticky_flag
// One status flag that holds until cleared; a set beats a clear in the same cycle.
module rtc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q;

    // Set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set_i)
            q <= 1'b1;
        else if (clr_i)
            q <= 1'b0;
    end

    assign q_o = q;

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q); // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q); // R9

endmodule

// File: rtl/rtc_upd_seq.sv
// Module: rtc_upd_seq (top)
// Once-per-second update sequencer for a real-time clock with two alarm sets.
// It expects the external calendar to advance its bytes on the clock edge
// where adv_o is high. The alarm comparison uses the bytes present two
// cycles after the strobe.
module rtc_upd_seq
    import rtc_upd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en_i,
    input  logic [TIME_W-1:0]  cur_time_i,
    input  logic [ALM_A_W-1:0] alarm_a_i,
    input  logic [TIME_W-1:0]  alarm_b_i,
    input  logic               clr_uf_i,
    input  logic               clr_afa_i,
    input  logic               clr_afb_i,
    output logic               uip_o,
    output logic               adv_o,
    output logic               uf_o,
    output logic               afa_o,
    output logic               afb_o
);

    logic                 fin;
    logic                 hit_a;
    logic                 hit_b;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    rtc_tick_timer #(
        .TICKS (TICKS_PER_SEC),
        .LEAD  (LEAD_TICKS)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_en_i),
        .uip_o  (uip_o),
        .adv_o  (adv_o),
        .fin_o  (fin)
    );

    rtc_alarm_match #(.NBYTES(ALM_A_BYTES)) i_match_a (
        .time_i  (cur_time_i[ALM_A_W-1:0]),
        .alarm_i (alarm_a_i),
        .hit_o   (hit_a)
    );

    rtc_alarm_match #(.NBYTES(TIME_BYTES)) i_match_b (
        .time_i  (cur_time_i),
        .alarm_i (alarm_b_i),
        .hit_o   (hit_b)
    );

    // Sets happen only at the end of an update; clears come from the strobes
    always_comb begin
        flag_set[FLAG_UF]  = fin;
        flag_set[FLAG_AFA] = fin && hit_a;
        flag_set[FLAG_AFB] = fin && hit_b;
        flag_clr[FLAG_UF]  = clr_uf_i;
        flag_clr[FLAG_AFA] = clr_afa_i;
        flag_clr[FLAG_AFB] = clr_afb_i;
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        rtc_sticky_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[f]),
            .clr_i (flag_clr[f]),
            .q_o   (flag_q[f])
        );
    end

    assign uf_o  = flag_q[FLAG_UF];
    assign afa_o = flag_q[FLAG_AFA];
    assign afb_o = flag_q[FLAG_AFB];

    AST_UF_AT_UPDATE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip_o) |-> uf_o); // R3
    AST_AFA_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afa_o) |-> $fell(uip_o)); // R10
    AST_AFB_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afb_o) |-> $fell(uip_o)); // R10

endmodule

// File: tb/test_rtc_upd_seq.sv
`timescale 1ns/1ps
// Directed bench: each task runs one scenario and checks its own results.
module test_rtc_upd_seq;

    localparam int P = 64;
    localparam int L = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en_i;
    logic [63:0] cur_time_i;
    logic [23:0] alarm_a_i;
    logic [63:0] alarm_b_i;
    logic        clr_uf_i, clr_afa_i, clr_afb_i;
    logic        uip_o, adv_o, uf_o, afa_o, afb_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench-side time model
    logic [63:0] pre_time, next_time;
    logic        applied;
    logic        tick_run;
    logic [1:0]  div;
    int          ticks;

    always #2.5 clk = ~clk;

    rtc_upd_seq #(.TICKS_PER_SEC(P), .LEAD_TICKS(L)) i_rtc_upd_seq (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .cur_time_i(cur_time_i), .alarm_a_i(alarm_a_i), .alarm_b_i(alarm_b_i),
        .clr_uf_i(clr_uf_i), .clr_afa_i(clr_afa_i), .clr_afb_i(clr_afb_i),
        .uip_o(uip_o), .adv_o(adv_o), .uf_o(uf_o), .afa_o(afa_o), .afb_o(afb_o)
    );

    // Tick enable: one cycle in four while running
    always @(negedge clk) begin
        if (!tick_run) begin
            div       <= 2'd0;
            tick_en_i <= 1'b0;
        end else begin
            div       <= div + 2'd1;
            tick_en_i <= (div == 2'd3);
        end
    end

    // Count ticks seen by the design; model the calendar advance
    always @(posedge clk) begin
        if (!rst_n) begin
            ticks   <= 0;
            applied <= 1'b0;
        end else begin
            if (tick_en_i) ticks <= ticks + 1;
            if (adv_o) applied <= 1'b1;
        end
    end
    assign cur_time_i = applied ? next_time : pre_time;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tick_run  = 1'b0;
        rst_n     = 1'b0;
        clr_uf_i  = 1'b0;
        clr_afa_i = 1'b0;
        clr_afb_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_uip(input logic lvl);
        int n = 0;
        while (uip_o !== lvl && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_adv();
        int n = 0;
        while (adv_o !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_update();
        wait_uip(1'b1);
        wait_uip(1'b0);
    endtask

    task automatic pulse_clear(input logic u, input logic a, input logic b);
        clr_uf_i = u; clr_afa_i = a; clr_afb_i = b;
        @(negedge clk);
        clr_uf_i = 1'b0; clr_afa_i = 1'b0; clr_afb_i = 1'b0;
    endtask

    // Reset state and sequence timing
    task automatic t_timing();
        pre_time = 64'h2024_0615_0308_3045; next_time = pre_time;
        alarm_a_i = 24'h0; alarm_b_i = 64'h0;
        do_reset();
        check("R11 outputs after reset", {uip_o, adv_o, uf_o, afa_o, afb_o}, 5'b0);
        tick_run = 1'b1;
        wait_uip(1'b1);
        check("R1 ticks at uip rise", ticks, P - L);
        check("R2 no strobe at uip rise", adv_o, 1'b0);
        wait_adv();
        check("R2 ticks at strobe", ticks, P);
        check("R2 uip high during strobe", uip_o, 1'b1);
        @(negedge clk);
        check("R2 strobe one cycle", adv_o, 1'b0);
        check("R3 uip still high after strobe", uip_o, 1'b1);
        check("R3 uf not yet set", uf_o, 1'b0);
        @(negedge clk);
        check("R3 uip cleared", uip_o, 1'b0);
        check("R3 uf set", uf_o, 1'b1);
        wait_uip(1'b1);
        check("R4 ticks at second uip rise", ticks, 2 * P - L);
        wait_adv();
        check("R4 ticks at second strobe", ticks, 2 * P);
    endtask

    // Alarm A uses the advanced time and only at update end
    task automatic t_alarm_a();
        pre_time  = 64'h2024_0615_0308_3045;
        next_time = 64'h2024_0615_0308_3046;
        alarm_a_i = 24'h08_30_45; alarm_b_i = 64'h0;
        do_reset();
        tick_run = 1'b1;
        wait_uip(1'b1);
        check("R10 no flag from pre-update match", afa_o, 1'b0);
        wait_uip(1'b0);
        check("R5 old time not used", afa_o, 1'b0);
        alarm_a_i = 24'h08_30_46;
        wait_uip(1'b1);
        check("R10 matching time mid-second sets nothing", afa_o, 1'b0);
        wait_uip(1'b0);
        check("R5 advanced time matches", afa_o, 1'b1);
        check("R6 alarm B mismatch stays low", afb_o, 1'b0);
    endtask

    // Alarm B compares all eight bytes
    task automatic t_alarm_b();
        pre_time  = 64'h2024_0615_0308_3045;
        next_time = 64'h2024_0615_0308_3046;
        alarm_a_i = 24'h00_00_00; alarm_b_i = next_time;
        do_reset();
        tick_run = 1'b1;
        run_update();
        check("R6 full match", afb_o, 1'b1);
        check("R5 alarm A mismatch low", afa_o, 1'b0);
        pulse_clear(1'b0, 1'b0, 1'b1);
        check("R8 clear alarm B", afb_o, 1'b0);
        check("R8 uf untouched by other clear", uf_o, 1'b1);
        alarm_b_i = {8'h19, next_time[55:0]};
        run_update();
        check("R6 century differs", afb_o, 1'b0);
        alarm_b_i = {next_time[63:32], 8'h04, next_time[23:0]};
        run_update();
        check("R6 day of week differs", afb_o, 1'b0);
    endtask

    // Wildcard bytes
    task automatic t_wildcard();
        pre_time  = 64'h2024_0615_0308_3045;
        next_time = 64'h2024_0615_0308_3046;
        alarm_a_i = 24'hC0_C0_C0;
        alarm_b_i = {next_time[63:24], 8'hFF, 8'hC0, 8'hC0};
        do_reset();
        tick_run = 1'b1;
        run_update();
        check("R7 alarm A all wildcards", afa_o, 1'b1);
        check("R7 alarm B FFh and C0h wildcards", afb_o, 1'b1);
        pulse_clear(1'b1, 1'b1, 1'b1);
        alarm_a_i = 24'hC0_C0_80;
        alarm_b_i = {next_time[63:16], 8'h40, next_time[7:0]};
        run_update();
        check("R7 80h is not a wildcard", afa_o, 1'b0);
        check("R7 40h is not a wildcard", afb_o, 1'b0);
    endtask

    // Sticky behaviour and set-over-clear priority
    task automatic t_sticky();
        pre_time  = 64'h2024_0615_0308_3045;
        next_time = 64'h2024_0615_0308_3046;
        alarm_a_i = next_time[23:0]; alarm_b_i = next_time;
        do_reset();
        tick_run = 1'b1;
        run_update();
        check("R8 alarm A set", afa_o, 1'b1);
        alarm_a_i = 24'h11_11_11;
        run_update();
        check("R8 alarm A holds through non-matching update", afa_o, 1'b1);
        repeat (20) @(negedge clk);
        check("R8 uf holds without clear", uf_o, 1'b1);
        alarm_a_i = next_time[23:0];
        wait_adv();
        @(negedge clk);
        pulse_clear(1'b1, 1'b1, 1'b1);
        check("R9 uf set wins over clear", uf_o, 1'b1);
        check("R9 alarm A set wins over clear", afa_o, 1'b1);
        check("R9 alarm B set wins over clear", afb_o, 1'b1);
        pulse_clear(1'b1, 1'b0, 1'b0);
        check("R8 uf cleared by its strobe", uf_o, 1'b0);
        check("R8 alarm A kept by other clear", afa_o, 1'b1);
        pulse_clear(1'b0, 1'b1, 1'b1);
        check("R8 alarm A cleared", afa_o, 1'b0);
        check("R8 alarm B cleared", afb_o, 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_run = 1'b0;
        clr_uf_i = 1'b0; clr_afa_i = 1'b0; clr_afb_i = 1'b0;
        pre_time = '0; next_time = '0; alarm_a_i = '0; alarm_b_i = '0;
        t_timing();
        t_alarm_a();
        t_alarm_b();
        t_wildcard();
        t_sticky();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule